// File: doc/BRIEF.md
# FIFO Transmit Interval Pacer

This block spaces out consecutive frame transmissions taken from a shared transmit/receive message FIFO. It holds one 16-bit control register. The register sets how many interval ticks must pass after each completed transmission. It also selects where those ticks come from and which mode the FIFO is in. After every `tx_done` pulse in transmit mode, the block holds `tx_grant` low until the programmed number of ticks has elapsed. After that it passes `tx_req` through to `tx_grant` again.

The interval tick has three possible sources:
- the system clock halved and then divided by the 16-bit `prescale` input;
- that same path divided by a further ten;
- the external bit-time strobe.

Pacing runs only while the FIFO is enabled and the mode field is 01. In any other condition the grant simply follows the request, and the interval counter and the prescaler are held cleared.

The pacing control is a two-state machine:
- **READY**: the grant follows the request.
- **HOLD**: the grant is blocked.

Its transitions are:
- **LOAD** (READY→HOLD or HOLD→HOLD): taken on `tx_done` in transmit mode with a non-zero interval. It loads the interval counter.
- **COUNT** (HOLD→HOLD): taken on a tick while more than one tick remains. It decrements the counter.
- **EXPIRE** (HOLD→READY): taken on the last tick.
- **ABORT** (any→READY): taken when the FIFO is disabled or leaves transmit mode.

Top module: `fifo_tx_pacer`

## Requirements
- R1: After reset every register bit reads 0. With the mode field therefore 00 (receive), `tx_grant` equals `tx_req`.
- R2: Register fields are: [15:8] interval, [7:6] reserved, [5:4] transmit-buffer link number, [3] resolution, [2] source select, [1:0] mode. The reserved bits always read 0, whatever value is written to them.
- R3: While `fifo_en` is 1, writes leave the interval and resolution fields unchanged. The link, source select and mode fields still take written values.
- R4: With an interval of 0, a `tx_done` adds no gap. `tx_grant` follows `tx_req` in the cycle after `tx_done`.
- R5: With source select 1 and a non-zero interval N, `tx_grant` is 0 from the cycle after `tx_done`. It is 1 again (with `tx_req` high) in the cycle after the clock edge at which the N-th `bit_strobe` pulse is seen.
- R6: With source select 0 and resolution 0, one tick occurs every 2×max(prescale,1) clock cycles. A prescale value of 0 acts as a divide by 1. The blocked time after `tx_done` lies between (N−1)·T+1 and N·T cycles.
- R7: With source select 0 and resolution 1, the tick period is 20×max(prescale,1) clock cycles.
- R8: Pacing happens only for mode 01. With mode 00, 10 or 11, `tx_grant` equals `tx_req` even after `tx_done`.
- R9: Clearing `fifo_en`, or writing a mode other than 01, ends any wait at once. When transmit mode resumes, the next request is granted without delay.
- R10: A `tx_done` during a wait reloads the full interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Current register value |
| prescale | input | 16 | Interval timer prescale value |
| fifo_en | input | 1 | FIFO enable; locks interval and resolution |
| bit_strobe | input | 1 | One-cycle bus bit-time strobe |
| tx_done | input | 1 | One-cycle pulse on completed transmission |
| tx_req | input | 1 | Transmit request from the FIFO |
| tx_grant | output | 1 | Transmit permission |

## Verification
The blocking window is first tried with the bit-time strobe as the tick source. Directed pulse counts check the exact release edge and the reload on a repeated `tx_done`. Random strobe densities and intervals then check that the count follows strobes, not clock cycles. The prescaled sources are measured against period bounds with prescale values of 0 and 3, and with the extra divide by ten. These runs tell the divide-by-one handling apart from the decade stage. Disable, mode-change and non-transmit-mode patterns separate the pacing path from plain pass-through.

// File: rtl/fifo_tx_pacer_pkg.sv
package fifo_tx_pacer_pkg;
    typedef enum logic [1:0] {
        MODE_RX   = 2'b00,
        MODE_TX   = 2'b01,
        MODE_RSV2 = 2'b10,
        MODE_RSV3 = 2'b11
    } fifo_mode_e;

    typedef enum logic {
        PS_READY = 1'b0,
        PS_HOLD  = 1'b1
    } pace_state_e;
endpackage

// File: rtl/fifo_tx_pacer_cfg.sv
module fifo_tx_pacer_cfg #(
    parameter int IVL_W  = 8,
    parameter int LINK_W = 2,
    localparam int REG_W = IVL_W + 2 + LINK_W + 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    input  logic             lock,
    output logic [REG_W-1:0] rdata,
    output logic [IVL_W-1:0] interval,
    output logic             res_dec,
    output logic             src_bit,
    output logic [1:0]       mode
);
    logic [LINK_W-1:0] link_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            interval <= '0;
            res_dec  <= 1'b0;
            src_bit  <= 1'b0;
            mode     <= 2'b00;
            link_q   <= '0;
        end else if (we) begin
            if (!lock) begin
                interval <= wdata[REG_W-1 -: IVL_W];
                res_dec  <= wdata[3];
            end
            src_bit <= wdata[2];
            mode    <= wdata[1:0];
            link_q  <= wdata[4 +: LINK_W];
        end
    end

    assign rdata = {interval, 2'b00, link_q, res_dec, src_bit, mode};

    a_r3_interval_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (we && lock) |=> ($stable(interval) && $stable(res_dec)));
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[LINK_W+5:LINK_W+4] == 2'b00);
endmodule

// File: rtl/fifo_tx_pacer_tick.sv
module fifo_tx_pacer_tick #(
    parameter int PRE_W   = 16,
    parameter int DEC_MOD = 10,
    localparam int DEC_W  = $clog2(DEC_MOD)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             src_bit,
    input  logic             res_dec,
    input  logic             bit_strobe,
    input  logic [PRE_W-1:0] prescale,
    output logic             tick
);
    logic             half_q;
    logic [PRE_W-1:0] pre_q;
    logic [DEC_W-1:0] dec_q;
    logic [PRE_W-1:0] pre_last;
    logic             base_tc;
    logic             dec_tc;

    assign pre_last = (prescale == '0) ? '0 : prescale - 1'b1;
    assign base_tc  = run && half_q && (pre_q >= pre_last);
    assign dec_tc   = base_tc && (dec_q == DEC_W'(DEC_MOD - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_q <= 1'b0;
            pre_q  <= '0;
            dec_q  <= '0;
        end else if (!run) begin
            half_q <= 1'b0;
            pre_q  <= '0;
            dec_q  <= '0;
        end else begin
            half_q <= ~half_q;
            if (base_tc) begin
                pre_q <= '0;
                dec_q <= dec_tc ? '0 : dec_q + 1'b1;
            end else if (half_q) begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end

    always_comb begin
        if (!run)         tick = 1'b0;
        else if (src_bit) tick = bit_strobe;
        else if (res_dec) tick = dec_tc;
        else              tick = base_tc;
    end

    a_r6_halved_clock: assert property (@(posedge clk) disable iff (!rst_n)
        base_tc |=> !base_tc);
    a_r9_idle_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !tick);
endmodule

// File: rtl/fifo_tx_pacer_fsm.sv
module fifo_tx_pacer_fsm
    import fifo_tx_pacer_pkg::*;
#(
    parameter int IVL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             tx_done,
    input  logic             tick,
    input  logic [IVL_W-1:0] interval,
    input  logic             tx_req,
    output logic             tx_grant
);
    pace_state_e      state_q, state_d;
    logic [IVL_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PS_READY;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (!active) begin
            state_d = PS_READY;
            cnt_d   = '0;
        end else if (tx_done) begin
            if (interval != '0) begin
                state_d = PS_HOLD;
                cnt_d   = interval;
            end
        end else begin
            unique case (state_q)
                PS_READY: ;
                PS_HOLD: begin
                    if (tick) begin
                        if (cnt_q <= IVL_W'(1)) begin
                            state_d = PS_READY;
                            cnt_d   = '0;
                        end else begin
                            cnt_d = cnt_q - 1'b1;
                        end
                    end
                end
                default: state_d = PS_READY;
            endcase
        end
    end

    always_comb begin
        if (!active) tx_grant = tx_req;
        else         tx_grant = tx_req && (state_q == PS_READY);
    end

    a_r5_grant_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        tx_grant |-> tx_req);
    a_r5_hold_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        (active && tx_done && interval != '0) |=> (!tx_grant || !active));
    a_r8_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (tx_grant == tx_req));
endmodule

// File: rtl/fifo_tx_pacer.sv
module fifo_tx_pacer
    import fifo_tx_pacer_pkg::*;
#(
    parameter int IVL_W   = 8,
    parameter int LINK_W  = 2,
    parameter int PRE_W   = 16,
    parameter int DEC_MOD = 10,
    localparam int REG_W  = IVL_W + 2 + LINK_W + 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic [REG_W-1:0] cfg_rdata,
    input  logic [PRE_W-1:0] prescale,
    input  logic             fifo_en,
    input  logic             bit_strobe,
    input  logic             tx_done,
    input  logic             tx_req,
    output logic             tx_grant
);
    logic [IVL_W-1:0] interval;
    logic             res_dec;
    logic             src_bit;
    logic [1:0]       mode;
    logic             active;
    logic             tick;

    fifo_tx_pacer_cfg #(.IVL_W(IVL_W), .LINK_W(LINK_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .wdata    (cfg_wdata),
        .lock     (fifo_en),
        .rdata    (cfg_rdata),
        .interval (interval),
        .res_dec  (res_dec),
        .src_bit  (src_bit),
        .mode     (mode)
    );

    assign active = fifo_en && (mode == MODE_TX);

    fifo_tx_pacer_tick #(.PRE_W(PRE_W), .DEC_MOD(DEC_MOD)) u_tick (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (active),
        .src_bit    (src_bit),
        .res_dec    (res_dec),
        .bit_strobe (bit_strobe),
        .prescale   (prescale),
        .tick       (tick)
    );

    fifo_tx_pacer_fsm #(.IVL_W(IVL_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (active),
        .tx_done  (tx_done),
        .tick     (tick),
        .interval (interval),
        .tx_req   (tx_req),
        .tx_grant (tx_grant)
    );
endmodule

// File: tb/fifo_tx_pacer_bench.sv
module fifo_tx_pacer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic [15:0] prescale = '0;
    logic        fifo_en = 1'b0;
    logic        bit_strobe = 1'b0;
    logic        tx_done = 1'b0;
    logic        tx_req = 1'b0;
    logic        tx_grant;
    int          n_chk = 0;
    int          n_fail = 0;

    always #2 clk = ~clk;

    fifo_tx_pacer u_fifo_tx_pacer (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .prescale(prescale), .fifo_en(fifo_en),
        .bit_strobe(bit_strobe), .tx_done(tx_done), .tx_req(tx_req),
        .tx_grant(tx_grant)
    );

    function automatic logic [15:0] cfg_word(input logic [7:0] ivl, input logic [1:0] lnk,
                                             input logic res, input logic src, input logic [1:0] md);
        return {ivl, 2'b00, lnk, res, src, md};
    endfunction

    function automatic int tick_period(input int pre, input logic res);
        int base;
        base = 2 * ((pre == 0) ? 1 : pre);
        return res ? base * 10 : base;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_range(input string req, input int act, input int lo, input int hi);
        n_chk++;
        if (act < lo || act > hi) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic wr(input logic [15:0] d);
        cfg_we = 1'b1; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic done_pulse();
        tx_done = 1'b1;
        @(negedge clk);
        tx_done = 1'b0;
    endtask

    task automatic strobe_pulse();
        bit_strobe = 1'b1;
        @(negedge clk);
        bit_strobe = 1'b0;
    endtask

    task automatic setup(input logic [15:0] d);
        fifo_en = 1'b0;
        @(negedge clk);
        wr(d);
        fifo_en = 1'b1;
        @(negedge clk);
    endtask

    task automatic measure(input string req, input int pre, input logic res, input int n);
        int cnt;
        int t;
        prescale = 16'(pre);
        setup(cfg_word(8'(n), 2'b00, res, 1'b0, 2'b01));
        t = tick_period(pre, res);
        done_pulse();
        cnt = 0;
        while (!tx_grant && cnt < 2000) begin
            cnt++;
            @(negedge clk);
        end
        check_range(req, cnt, (n - 1) * t + 1, n * t);
    endtask

    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        tx_req = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset rdata", int'(cfg_rdata), 0);
        check("R1 reset grant", int'(tx_grant), 1);

        wr(16'hFFFF);
        check("R2 reserved bits", int'(cfg_rdata), 16'hFF3F);
        wr(16'h0000);

        for (int m = 0; m < 4; m++) begin
            if (m != 1) begin
                setup(cfg_word(8'h05, 2'b00, 1'b0, 1'b1, 2'(m)));
                done_pulse();
                check("R8 non-tx mode grant", int'(tx_grant), 1);
            end
        end

        setup(cfg_word(8'h00, 2'b00, 1'b0, 1'b1, 2'b01));
        done_pulse();
        check("R4 zero interval", int'(tx_grant), 1);

        wr(cfg_word(8'h33, 2'b10, 1'b1, 1'b1, 2'b01));
        check("R3 locked fields", int'(cfg_rdata), int'(cfg_word(8'h00, 2'b10, 1'b0, 1'b1, 2'b01)));
        done_pulse();
        check("R3 interval still zero", int'(tx_grant), 1);

        setup(cfg_word(8'd3, 2'b00, 1'b0, 1'b1, 2'b01));
        done_pulse();
        check("R5 blocked after done", int'(tx_grant), 0);
        strobe_pulse(); strobe_pulse();
        repeat (3) @(negedge clk);
        check("R5 blocked after two strobes", int'(tx_grant), 0);
        strobe_pulse();
        check("R5 released after third strobe", int'(tx_grant), 1);

        setup(cfg_word(8'd2, 2'b00, 1'b0, 1'b1, 2'b01));
        done_pulse();
        strobe_pulse();
        done_pulse();
        strobe_pulse();
        check("R10 reload keeps blocked", int'(tx_grant), 0);
        strobe_pulse();
        check("R10 release after reload", int'(tx_grant), 1);

        setup(cfg_word(8'd4, 2'b00, 1'b0, 1'b1, 2'b01));
        done_pulse();
        check("R9 blocked before disable", int'(tx_grant), 0);
        fifo_en = 1'b0;
        @(negedge clk);
        check("R9 disable releases", int'(tx_grant), 1);
        fifo_en = 1'b1;
        @(negedge clk);
        check("R9 re-enable granted", int'(tx_grant), 1);
        done_pulse();
        wr(cfg_word(8'd4, 2'b00, 1'b0, 1'b1, 2'b00));
        check("R9 leaving tx mode releases", int'(tx_grant), 1);
        wr(cfg_word(8'd4, 2'b00, 1'b0, 1'b1, 2'b01));
        check("R9 back in tx mode granted", int'(tx_grant), 1);

        measure("R6 prescale 3 interval 2", 3, 1'b0, 2);
        measure("R6 prescale 0 interval 3", 0, 1'b0, 3);
        measure("R7 decade prescale 3 interval 1", 3, 1'b1, 1);
        measure("R7 decade prescale 1 interval 2", 1, 1'b1, 2);

        for (int it = 0; it < 40; it++) begin
            int n;
            int rem;
            int dens;
            n = int'($urandom % 8);
            dens = 2 + int'($urandom % 4);
            setup(cfg_word(8'(n), 2'b00, 1'b0, 1'b1, 2'b01));
            done_pulse();
            rem = n;
            check("R5 random after done", int'(tx_grant), (rem == 0) ? 1 : 0);
            for (int c = 0; c < 3 * n + 4; c++) begin
                logic s;
                s = (($urandom % dens) == 0);
                bit_strobe = s;
                @(negedge clk);
                if (s && rem > 0) rem--;
                check("R5 random strobe count", int'(tx_grant), (rem == 0) ? 1 : 0);
            end
            bit_strobe = 1'b0;
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule